// File: doc/BRIEF.md
# Single-Channel Block DMA Engine

This block copies a run of bytes between host memory and a 4096-byte buffer held inside the device. The buffer is reached through a fixed local address window starting at 0x40000. Software programs a source address, a destination address and a byte count. It then writes a command word that starts the job and selects the direction. The direction decides which of the two addresses is the local one. The other address is a host address, and it is ANDed with a configurable mask before it reaches the byte-wide host port.

After a command is accepted, the engine waits a fixed number of clock cycles. It then checks that the whole local range fits inside the buffer window. If the range fits, it moves one byte per host handshake until the count is used up. A range that does not fit aborts the job and sets a sticky error flag. While a job is running, all four DMA registers are frozen. Software detects completion by polling the busy bit. If the job asked for it, the engine also pulses an interrupt request.

Top module: `dma_engine`

## Requirements
- R1: After reset every DMA register reads 0, `hst_req` is low and `irq` is low.
- R2: The register offsets are 0x80 (source), 0x88 (destination), 0x90 (count) and 0x98 (command). A write with `reg_wide`=1 stores all 64 bits. A write with `reg_wide`=0 stores the low 32 bits and clears the upper 32 bits. Source, destination and count read back what was stored. Any other offset reads 0.
- R3: A command write with bit 0 = 1 starts a job. In that word, bit 1 is the direction (0 = host to buffer, 1 = buffer to host) and bit 2 enables the completion interrupt. The command readback has bit 0 = busy, bit 1 = direction, bit 2 = interrupt enable and bit 3 = error. A command write with bit 0 = 0 is ignored entirely.
- R4: While busy, writes to any of the four DMA registers are ignored.
- R5: After the edge that accepts a command, `hst_req` first rises on the (START_LAT+1)-th following rising edge.
- R6: During a transfer, `hst_req` is held high. `hst_addr` is the host base plus the byte index. The index advances by one on each edge where `hst_req` and `hst_ack` are both high. With direction 0, `hst_we`=0 and `hst_rdata` is stored at buffer offset (local base - 0x40000 + index). With direction 1, `hst_we`=1 and that buffer byte appears on `hst_wdata`.
- R7: Every host address presented is ANDed with HMASK (default 0x0FFF_FFFF).
- R8: Busy clears on the edge that accepts the last byte. If bit 2 of the command was set, `irq` is high for exactly the following cycle. A zero count completes at the end of the start delay without any request, and it signals the interrupt in the same way.
- R9: If the local range [base, base+count) is not entirely inside 0x40000..0x40FFF, then at the end of the start delay busy clears, no byte moves, no interrupt is raised and command bit 3 is set. Bit 3 stays set until the next accepted command, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| reg_addr | input | 8 | Register offset for both read and write |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` (combinational) |
| hst_req | output | 1 | Host byte request |
| hst_we | output | 1 | 1 = write the byte to host memory, 0 = read it |
| hst_addr | output | 64 | Masked host byte address |
| hst_wdata | output | 8 | Byte written to host memory |
| hst_ack | input | 1 | Host accepts the current byte |
| hst_rdata | input | 8 | Byte returned by host memory, valid with `hst_ack` |
| irq | output | 1 | One-cycle completion interrupt request |

## Verification
The assertions assume the host side behaves well. `hst_ack` has meaning only while `hst_req` is high, and `hst_rdata` is valid in the same cycle as the acknowledge. Inputs are known after reset and do not change near the clock edge. The bench changes every input on the falling edge. It derives `hst_rdata` from the presented address and toggles `hst_ack` in fixed patterns, both every cycle and one cycle in three. These rules let the stall and hold properties see both stalled and accepted handshakes. Register writes are made only through a task that pulses the strobe for one cycle. This keeps the lock and start properties tied to single write events.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam logic [7:0] OFF_SRC = 8'h80;
    localparam logic [7:0] OFF_DST = 8'h88;
    localparam logic [7:0] OFF_CNT = 8'h90;
    localparam logic [7:0] OFF_CMD = 8'h98;

    // command word bit positions
    localparam int CB_GO  = 0;
    localparam int CB_DIR = 1;
    localparam int CB_IEN = 2;
    localparam int CB_ERR = 3;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_MOVE = 2'd2
    } sq_state_e;

    // true when [lo, lo+n) lies inside [base, base+size)
    function automatic logic range_fits(input logic [63:0] lo,
                                        input logic [63:0] n,
                                        input logic [63:0] base,
                                        input logic [63:0] size);
        logic [64:0] top_end;
        logic [64:0] win_end;
        top_end = {1'b0, lo} + {1'b0, n};
        win_end = {1'b0, base} + {1'b0, size};
        return (lo >= base) && (top_end <= win_end);
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wen,
    input  logic        wide,
    input  logic [7:0]  addr,
    input  logic [63:0] wdata,
    output logic [63:0] rdata,
    input  logic        busy,
    input  logic        err,
    output logic [63:0] src,
    output logic [63:0] dst,
    output logic [63:0] cnt,
    output logic        dir,
    output logic        ien,
    output logic        start
);

    typedef struct packed {
        logic [63:0] src;
        logic [63:0] dst;
        logic [63:0] cnt;
        logic        dir;
        logic        ien;
    } regs_t;

    regs_t r_d, r_q;
    logic [63:0] wval;

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        wval  = wide ? wdata : {32'h0, wdata[31:0]};
        if (wen && !busy) begin
            case (addr)
                OFF_SRC: r_d.src = wval;
                OFF_DST: r_d.dst = wval;
                OFF_CNT: r_d.cnt = wval;
                OFF_CMD: begin
                    if (wdata[CB_GO]) begin
                        r_d.dir = wdata[CB_DIR];
                        r_d.ien = wdata[CB_IEN];
                        start   = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_SRC: rdata = r_q.src;
            OFF_DST: rdata = r_q.dst;
            OFF_CNT: rdata = r_q.cnt;
            OFF_CMD: begin
                rdata[CB_GO]  = busy;
                rdata[CB_DIR] = r_q.dir;
                rdata[CB_IEN] = r_q.ien;
                rdata[CB_ERR] = err;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign src = r_q.src;
    assign dst = r_q.dst;
    assign cnt = r_q.cnt;
    assign dir = r_q.dir;
    assign ien = r_q.ien;

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int          START_LAT = 16,
    parameter int          BUF_AW    = 12,
    parameter logic [63:0] WIN_BASE  = 64'h4_0000,
    parameter int          BUF_BYTES = 4096,
    parameter logic [63:0] HMASK     = 64'h0FFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir,
    input  logic              ien,
    input  logic [63:0]       src,
    input  logic [63:0]       dst,
    input  logic [63:0]       cnt,
    input  logic              hst_ack,
    input  logic [7:0]        hst_rdata,
    input  logic [7:0]        buf_rdata,
    output logic              busy,
    output logic              err,
    output logic              irq,
    output logic              hst_req,
    output logic              hst_we,
    output logic [63:0]       hst_addr,
    output logic [7:0]        hst_wdata,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [7:0]        buf_wdata
);

    localparam int LAT_W = $clog2(START_LAT + 2);

    typedef struct packed {
        sq_state_e   st;
        logic [LAT_W-1:0] lat;
        logic [63:0] idx;
        logic        err;
        logic        irq;
    } seq_t;

    seq_t s_d, s_q;
    logic [63:0] loc_base;
    logic [63:0] host_base;
    logic        fits;

    always_comb begin
        s_d       = s_q;
        s_d.irq   = 1'b0;
        loc_base  = dir ? src : dst;
        host_base = dir ? dst : src;
        fits      = range_fits(loc_base, cnt, WIN_BASE, 64'(BUF_BYTES));

        hst_req   = (s_q.st == SQ_MOVE);
        hst_we    = dir;
        hst_addr  = (host_base + s_q.idx) & HMASK;
        hst_wdata = buf_rdata;
        buf_addr  = BUF_AW'(loc_base - WIN_BASE + s_q.idx);
        buf_wdata = hst_rdata;
        buf_we    = hst_req && hst_ack && !dir;

        case (s_q.st)
            SQ_IDLE: begin
                if (start) begin
                    s_d.st  = SQ_WAIT;
                    s_d.lat = LAT_W'(START_LAT);
                    s_d.err = 1'b0;
                    s_d.idx = '0;
                end
            end
            SQ_WAIT: begin
                if (s_q.lat == '0) begin
                    if (cnt == '0) begin
                        s_d.st  = SQ_IDLE;
                        s_d.irq = ien;
                    end else if (!fits) begin
                        s_d.st  = SQ_IDLE;
                        s_d.err = 1'b1;
                    end else begin
                        s_d.st  = SQ_MOVE;
                    end
                end else begin
                    s_d.lat = s_q.lat - 1'b1;
                end
            end
            SQ_MOVE: begin
                if (hst_ack) begin
                    if (s_q.idx == cnt - 64'd1) begin
                        s_d.st  = SQ_IDLE;
                        s_d.irq = ien;
                    end else begin
                        s_d.idx = s_q.idx + 64'd1;
                    end
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, lat: '0, idx: '0, err: 1'b0, irq: 1'b0};
        else        s_q <= s_d;
    end

    assign busy = (s_q.st != SQ_IDLE);
    assign err  = s_q.err;
    assign irq  = s_q.irq;

endmodule

// File: rtl/dma_lbuf.sv
module dma_lbuf #(
    parameter int BUF_BYTES = 4096,
    parameter int BUF_AW    = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BUF_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    logic [7:0] mem_q [BUF_BYTES];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int          START_LAT = 16,
    parameter logic [63:0] WIN_BASE  = 64'h4_0000,
    parameter int          BUF_BYTES = 4096,
    parameter logic [63:0] HMASK     = 64'h0FFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wen,
    input  logic        reg_wide,
    input  logic [7:0]  reg_addr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        hst_req,
    output logic        hst_we,
    output logic [63:0] hst_addr,
    output logic [7:0]  hst_wdata,
    input  logic        hst_ack,
    input  logic [7:0]  hst_rdata,
    output logic        irq
);

    localparam int BUF_AW = $clog2(BUF_BYTES);

    logic        busy, err, dir, ien, start;
    logic [63:0] src_q, dst_q, cnt_q;
    logic        buf_we;
    logic [BUF_AW-1:0] buf_addr;
    logic [7:0]  buf_wdata, buf_rdata;

    dma_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (reg_wen),
        .wide  (reg_wide),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .busy  (busy),
        .err   (err),
        .src   (src_q),
        .dst   (dst_q),
        .cnt   (cnt_q),
        .dir   (dir),
        .ien   (ien),
        .start (start)
    );

    dma_seq #(
        .START_LAT (START_LAT),
        .BUF_AW    (BUF_AW),
        .WIN_BASE  (WIN_BASE),
        .BUF_BYTES (BUF_BYTES),
        .HMASK     (HMASK)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dir       (dir),
        .ien       (ien),
        .src       (src_q),
        .dst       (dst_q),
        .cnt       (cnt_q),
        .hst_ack   (hst_ack),
        .hst_rdata (hst_rdata),
        .buf_rdata (buf_rdata),
        .busy      (busy),
        .err       (err),
        .irq       (irq),
        .hst_req   (hst_req),
        .hst_we    (hst_we),
        .hst_addr  (hst_addr),
        .hst_wdata (hst_wdata),
        .buf_we    (buf_we),
        .buf_addr  (buf_addr),
        .buf_wdata (buf_wdata)
    );

    dma_lbuf #(
        .BUF_BYTES (BUF_BYTES),
        .BUF_AW    (BUF_AW)
    ) u_lbuf (
        .clk   (clk),
        .we    (buf_we),
        .addr  (buf_addr),
        .wdata (buf_wdata),
        .rdata (buf_rdata)
    );

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter logic [63:0] HMASK = 64'h0FFF_FFFF
) (
    input logic        clk,
    input logic        rst_n,
    input logic        hst_req,
    input logic        hst_ack,
    input logic [63:0] hst_addr,
    input logic        irq,
    input logic        busy,
    input logic        err,
    input logic [63:0] src,
    input logic [63:0] dst,
    input logic [63:0] cnt
);

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        hst_req |-> busy); // R5

    AST_ADDR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        hst_req |-> ((hst_addr & ~HMASK) == 64'h0)); // R7

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_req && !hst_ack) |=> (hst_req && $stable(hst_addr))); // R6

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8

    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(busy) && !busy)); // R8

    AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!hst_req && !irq)); // R9

    AST_LOCK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(src)); // R4

    AST_LOCK_DST: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dst)); // R4

    AST_LOCK_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cnt)); // R4

endmodule

bind dma_engine dma_engine_chk #(.HMASK(HMASK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hst_req  (hst_req),
    .hst_ack  (hst_ack),
    .hst_addr (hst_addr),
    .irq      (irq),
    .busy     (busy),
    .err      (err),
    .src      (src_q),
    .dst      (dst_q),
    .cnt      (cnt_q)
);

// File: tb/dma_engine_tb.sv
`timescale 1ns/1ps
module dma_engine_tb;

    localparam int          LAT  = 16;
    localparam logic [63:0] BASE = 64'h4_0000;
    localparam logic [63:0] MASK = 64'h0FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0, reg_wide = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        hst_req, hst_we, irq;
    logic [63:0] hst_addr;
    logic [7:0]  hst_wdata;
    logic        hst_ack = 1'b0;
    logic [7:0]  hst_rdata = 8'h0;

    int n_chk = 0, n_fail = 0, irq_seen = 0, cyc = 0, ack_every = 1;
    bit done = 0;

    always #5 clk = ~clk;

    dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_wide(reg_wide),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_ack(hst_ack), .hst_rdata(hst_rdata),
        .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    int          m_ph = 0, m_lat = 0;
    logic [63:0] m_src = '0, m_dst = '0, m_cnt = '0, m_idx = '0, loc, wv;
    logic        m_dir = 0, m_ien = 0, m_err = 0, m_irq = 0;
    logic [64:0] e;
    logic [7:0]  m_buf [longint];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_lat = 0; m_src = '0; m_dst = '0; m_cnt = '0; m_idx = '0;
            m_dir = 0; m_ien = 0; m_err = 0; m_irq = 0;
        end else begin
            m_irq = 0;
            loc = m_dir ? m_src : m_dst;
            if (m_ph == 0) begin
                if (reg_wen) begin
                    wv = reg_wide ? reg_wdata : {32'h0, reg_wdata[31:0]};
                    case (reg_addr)
                        8'h80: m_src = wv;
                        8'h88: m_dst = wv;
                        8'h90: m_cnt = wv;
                        8'h98: if (reg_wdata[0]) begin
                            m_dir = reg_wdata[1]; m_ien = reg_wdata[2];
                            m_err = 0; m_lat = LAT; m_ph = 1; m_idx = '0;
                        end
                        default: ;
                    endcase
                end
            end else if (m_ph == 1) begin
                if (m_lat == 0) begin
                    e = {1'b0, loc} + {1'b0, m_cnt};
                    if (m_cnt == 0) begin m_ph = 0; m_irq = m_ien; end
                    else if (loc < BASE || e > {1'b0, BASE} + 65'd4096) begin
                        m_ph = 0; m_err = 1;
                    end else m_ph = 2;
                end else m_lat--;
            end else begin
                if (hst_ack) begin
                    if (!m_dir) m_buf[longint'(loc - BASE + m_idx)] = hst_rdata;
                    if (m_idx == m_cnt - 1) begin m_ph = 0; m_irq = m_ien; end
                    else m_idx++;
                end
            end
        end
    end

    // host side stimulus, changed away from the active edge
    always @(negedge clk) begin
        cyc++;
        hst_rdata <= hst_addr[7:0] ^ hst_addr[15:8] ^ 8'hA5;
        hst_ack   <= (ack_every <= 1) ? 1'b1 : ((cyc % ack_every) == 0);
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [63:0] xa;
            n_chk++;
            if (hst_req !== (m_ph == 2)) begin
                n_fail++; $display("FAIL R5 hst_req act=%0b exp=%0b", hst_req, (m_ph == 2));
            end
            n_chk++;
            if (irq !== m_irq) begin
                n_fail++; $display("FAIL R8 irq act=%0b exp=%0b", irq, m_irq);
            end
            if (irq === 1'b1) irq_seen++;
            if (m_ph == 2) begin
                xa = ((m_dir ? m_dst : m_src) + m_idx) & MASK;
                n_chk++;
                if (hst_addr !== xa || hst_we !== m_dir) begin
                    n_fail++; $display("FAIL R7 addr/we act=%h/%0b exp=%h/%0b", hst_addr, hst_we, xa, m_dir);
                end
                if (m_dir) begin
                    n_chk++;
                    if (hst_wdata !== m_buf[longint'(m_src - BASE + m_idx)]) begin
                        n_fail++; $display("FAIL R6 wdata act=%h exp=%h", hst_wdata,
                                           m_buf[longint'(m_src - BASE + m_idx)]);
                    end
                end
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic w);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d; reg_wide = w;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [63:0] v;
        for (int i = 0; i < 2000; i++) begin
            rd(8'h98, v);
            if (v[0] == 1'b0) break;
        end
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [63:0] v;
        int k, irq0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R2 unmapped offset
        rd(8'h80, v); chk("R1 src", v, 0);
        rd(8'h88, v); chk("R1 dst", v, 0);
        rd(8'h90, v); chk("R1 cnt", v, 0);
        rd(8'h98, v); chk("R1 cmd", v, 0);
        rd(8'h00, v); chk("R2 unmapped", v, 0);
        chk("R1 req", {63'h0, hst_req}, 0);
        chk("R1 irq", {63'h0, irq}, 0);

        // R2 wide and narrow writes
        wr(8'h80, 64'hFFFF_0001_2345_6700, 1'b1);
        rd(8'h80, v); chk("R2 wide src", v, 64'hFFFF_0001_2345_6700);
        wr(8'h88, 64'hDEAD_BEEF_0004_0010, 1'b0);
        rd(8'h88, v); chk("R2 narrow dst", v, 64'h4_0010);
        wr(8'h90, 64'd6, 1'b0);

        // host -> buffer with stalls, interrupt enabled
        ack_every = 3;
        irq0 = irq_seen;
        wr(8'h98, 64'h5, 1'b0);
        k = 0;
        while (hst_req !== 1'b1 && k < 100) begin @(negedge clk); k++; end
        chk("R5 start latency", 64'(k), 64'(LAT + 1));
        rd(8'h98, v); chk("R3 busy bit", v, 64'h5);
        wr(8'h80, 64'h111, 1'b1);                    // R4 locked write
        wr(8'h98, 64'h3, 1'b0);                      // R4 locked command
        wait_idle();
        rd(8'h80, v); chk("R4 src locked", v, 64'hFFFF_0001_2345_6700);
        rd(8'h98, v); chk("R8 cmd after done", v, 64'h4);
        chk("R8 one irq", 64'(irq_seen - irq0), 1);

        // R3 start bit zero ignored
        ack_every = 1;
        wr(8'h98, 64'h6, 1'b0);
        repeat (LAT + 4) @(negedge clk);
        rd(8'h98, v); chk("R3 no-start ignored", v, 64'h4);

        // buffer -> host, no interrupt
        irq0 = irq_seen;
        wr(8'h80, 64'h4_0010, 1'b0);
        wr(8'h88, 64'h1000_0200, 1'b1);
        wr(8'h98, 64'h3, 1'b0);
        wait_idle();
        rd(8'h98, v); chk("R6 dir1 done", v, 64'h2);
        chk("R8 no irq when disabled", 64'(irq_seen - irq0), 0);

        // R9 window overrun at the top
        wr(8'h80, 64'h500, 1'b0);
        wr(8'h88, 64'h4_0FFC, 1'b0);
        wr(8'h90, 64'd8, 1'b0);
        wr(8'h98, 64'h5, 1'b0);
        wait_idle();
        rd(8'h98, v); chk("R9 overrun error", v, 64'hC);
        chk("R9 no irq on error", 64'(irq_seen - irq0), 0);

        // R9 below window
        wr(8'h88, 64'h3_FFFF, 1'b0);
        wr(8'h90, 64'd1, 1'b0);
        wr(8'h98, 64'h1, 1'b0);
        wait_idle();
        rd(8'h98, v); chk("R9 below window", v, 64'h8);

        // R9 exact fit at window end clears the error
        wr(8'h88, 64'h4_0FFC, 1'b0);
        wr(8'h90, 64'd4, 1'b0);
        wr(8'h98, 64'h5, 1'b0);
        wait_idle();
        rd(8'h98, v); chk("R9 fit clears error", v, 64'h4);
        chk("R8 irq after fit", 64'(irq_seen - irq0), 1);

        // R9 count wraps the address space
        wr(8'h88, 64'h4_0000, 1'b0);
        wr(8'h90, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        wr(8'h98, 64'h1, 1'b0);
        wait_idle();
        rd(8'h98, v); chk("R9 wrap error", v, 64'h8);

        // R8 zero count
        irq0 = irq_seen;
        wr(8'h90, 64'd0, 1'b0);
        wr(8'h98, 64'h5, 1'b0);
        wait_idle();
        repeat (2) @(negedge clk);
        rd(8'h98, v); chk("R8 zero count", v, 64'h4);
        chk("R8 zero count irq", 64'(irq_seen - irq0), 1);

        repeat (4) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule